// File: doc/BRIEF.md
# Single-Channel Patterned Block DMA Engine

This block moves a run of bytes between a wide memory-side address (an 8-bit bank plus a 16-bit offset) and a narrow register-side index. Software loads a small set of channel registers through a byte-wide register port and then pulses `start`. The engine issues one read per cycle on the source side and, two cycles later, the matching write on the destination side. It keeps `busy` high until the last write has been presented. When the run ends, the engine stores the final memory offset back into the offset register and clears the byte count.

The register-side index does not simply stay put or count up. A 3-bit transfer pattern picks a short repeating sequence of small offsets (0, 1, 2 or 3) that is added to the base index for each byte, so one run can feed a pair or a quartet of neighbouring registers. The memory-side offset can stay fixed, count up or count down, and it wraps within its 16 bits. The direction bit selects memory-to-register or register-to-memory.

One combination is treated as an internal no-op: a memory-to-register run from bank 0x7E or 0x7F into index 0x80. In that case the engine moves no data. It stays busy for the count plus one cycle and advances the offset by the programmed count.

Top module: `blk_dma_engine`

## Requirements
- R1: After reset the channel registers read back as: control 0x0F (memory-to-register, fixed stepping, pattern 7), index 0xFF, offset 0xFFFF, bank 0xFF, count 0xFFFF. `busy`, `a_req` and `b_req` are low.
- R2: The register map is: select 0 control (bit 7 direction, 1 = register-to-memory; bit 4 count down; bit 3 hold offset; bits 2:0 pattern), 1 index, 2 offset low byte, 3 offset high byte, 4 bank, 5 count low byte, 6 count high byte. `reg_rdata` shows the selected register one cycle after `reg_sel` is presented.
- R3: A programmed count of 0 moves 65536 bytes.
- R4: Byte k uses memory offset base+k, base-k, or base, for count-up, count-down (hold clear) and hold set respectively. The offset wraps modulo 65536 and the bank stays unchanged.
- R5: Patterns 0, 2 and 6 add 0 to the index for every byte.
- R6: Patterns 1 and 5 add 0,1,0,1,... to the index. Patterns 3 and 7 add 0,0,1,1,... The index sum wraps modulo 256.
- R7: Pattern 4 adds 0,1,2,3,0,... A count that is not a multiple of the group length stops exactly after the last counted byte.
- R8: Take the edge that samples `start` as edge 0. Read k is presented in the cycle after edge k+1. The read data is expected in the following cycle. Write k, carrying that data, is presented in the cycle after edge k+3. `busy` is high for count+3 cycles.
- R9: With direction 1, the engine reads the register side at the patterned index and writes the memory side at the stepped offset, with the same timing.
- R10: A memory-to-register run from bank 0x7E or 0x7F into index 0x80 issues no accesses on either side. `busy` is high for count+1 cycles, and the offset advances by the programmed count regardless of stepping.
- R11: When `busy` falls, the offset register holds the final offset and the count register reads 0.
- R12: A `start` pulse while `busy` is high has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Registered read byte of the selected register |
| start | input | 1 | Begin a transfer (ignored while busy) |
| busy | output | 1 | Transfer in progress |
| a_req | output | 1 | Memory-side access request |
| a_we | output | 1 | Memory-side write enable |
| a_addr | output | 24 | Memory-side address {bank, offset} |
| a_wdata | output | 8 | Memory-side write byte |
| a_rdata | input | 8 | Memory-side read byte, valid the cycle after a read request |
| b_req | output | 1 | Register-side access request |
| b_we | output | 1 | Register-side write enable |
| b_addr | output | 8 | Register-side index |
| b_wdata | output | 8 | Register-side write byte |
| b_rdata | input | 8 | Register-side read byte, valid the cycle after a read request |

## Verification
Each pattern family is run with counts that end partway through a group: 5 bytes in the pairing pattern and 7 in the quad pattern. This separates a correct early stop from one that rounds up to a full group. The offset runs cover counting up across the 0xFFFF wrap, counting down below zero and holding, so a sign or wrap error shows up in both the per-cycle address and the written-back offset. Register-to-memory runs use bank 0x7E with index 0x80, which shows that the no-op case depends on direction. The no-op runs set the count-down bit, so an engine that steps the offset there gives a different final value. A zero count checks the full 65536-byte length against the busy window.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int OFF_W  = 16;
  localparam int BANK_W = 8;
  localparam int BIDX_W = 8;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;
  localparam int SEL_W  = 3;
  localparam int LEN_W  = CNT_W + 1;
  localparam int AW     = BANK_W + OFF_W;

  typedef struct packed {
    logic       dir;
    logic       dec;
    logic       fixed;
    logic [2:0] mode;
  } ctrl_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 3'd0,
    SEL_BIDX   = 3'd1,
    SEL_OFF_LO = 3'd2,
    SEL_OFF_HI = 3'd3,
    SEL_BANK   = 3'd4,
    SEL_CNT_LO = 3'd5,
    SEL_CNT_HI = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  // index offset added for the byte at the given phase of the pattern
  function automatic logic [1:0] pattern_off(input logic [2:0] mode, input logic [1:0] phase);
    case (mode)
      3'd1, 3'd5: pattern_off = {1'b0, phase[0]};
      3'd3, 3'd7: pattern_off = {1'b0, phase[1]};
      3'd4:       pattern_off = phase;
      default:    pattern_off = 2'd0;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] step_val(input ctrl_t c);
    if (c.fixed)    step_val = '0;
    else if (c.dec) step_val = '1;
    else            step_val = OFF_W'(1);
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [7:0]        wdata,
  input  logic              wb_en,
  input  logic [OFF_W-1:0]  wb_off,
  output logic [7:0]        rdata,
  output ctrl_t             ctrl,
  output logic [BIDX_W-1:0] bidx,
  output logic [OFF_W-1:0]  off,
  output logic [BANK_W-1:0] bank,
  output logic [CNT_W-1:0]  cnt
);
  logic [7:0] ctrl_byte;
  assign ctrl_byte = {ctrl.dir, 2'b00, ctrl.dec, ctrl.fixed, ctrl.mode};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl  <= '{dir: 1'b0, dec: 1'b0, fixed: 1'b1, mode: 3'd7};
      bidx  <= '1;
      off   <= '1;
      bank  <= '1;
      cnt   <= '1;
      rdata <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(sel))
          SEL_CTRL:   ctrl <= '{dir: wdata[7], dec: wdata[4], fixed: wdata[3], mode: wdata[2:0]};
          SEL_BIDX:   bidx <= wdata;
          SEL_OFF_LO: off[7:0] <= wdata;
          SEL_OFF_HI: off[15:8] <= wdata;
          SEL_BANK:   bank <= wdata;
          SEL_CNT_LO: cnt[7:0] <= wdata;
          SEL_CNT_HI: cnt[15:8] <= wdata;
          default: ;
        endcase
      end
      if (wb_en) begin
        off <= wb_off;
        cnt <= '0;
      end
      case (reg_sel_e'(sel))
        SEL_CTRL:   rdata <= ctrl_byte;
        SEL_BIDX:   rdata <= bidx;
        SEL_OFF_LO: rdata <= off[7:0];
        SEL_OFF_HI: rdata <= off[15:8];
        SEL_BANK:   rdata <= bank;
        SEL_CNT_LO: rdata <= cnt[7:0];
        SEL_CNT_HI: rdata <= cnt[15:8];
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_eng_pkg::*;
#(
  parameter logic [BANK_W-1:0] NM_BANK0 = 8'h7E,
  parameter logic [BANK_W-1:0] NM_BANK1 = 8'h7F,
  parameter logic [BIDX_W-1:0] NM_BIDX  = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  ctrl_t             ctrl,
  input  logic [BIDX_W-1:0] bidx,
  input  logic [OFF_W-1:0]  off,
  input  logic [BANK_W-1:0] bank,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              pipe_busy,
  output logic              busy,
  output logic              iss_v,
  output logic [AW-1:0]     iss_a,
  output logic [BIDX_W-1:0] iss_b,
  output logic              dir_q,
  output logic              fixed_q,
  output logic              nomove_q,
  output logic [2:0]        mode_q,
  output logic              done,
  output logic [OFF_W-1:0]  wb_off
);
  logic [LEN_W-1:0]  left;
  logic [LEN_W-1:0]  len_ld;
  logic [OFF_W-1:0]  ptr;
  logic [OFF_W-1:0]  step_q;
  logic [1:0]        phase;
  logic [BANK_W-1:0] bank_q;
  logic [BIDX_W-1:0] bidx_q;
  logic              nm_hit;

  assign len_ld = (cnt == '0) ? (LEN_W'(1) << CNT_W) : {1'b0, cnt};
  assign nm_hit = !ctrl.dir && ((bank == NM_BANK0) || (bank == NM_BANK1)) && (bidx == NM_BIDX);
  assign done   = busy && (left == '0) && (nomove_q || (!iss_v && !pipe_busy));
  assign wb_off = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      iss_v    <= 1'b0;
      iss_a    <= '0;
      iss_b    <= '0;
      left     <= '0;
      ptr      <= '0;
      step_q   <= '0;
      phase    <= '0;
      bank_q   <= '0;
      bidx_q   <= '0;
      dir_q    <= 1'b0;
      fixed_q  <= 1'b0;
      nomove_q <= 1'b0;
      mode_q   <= '0;
    end else begin
      iss_v <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          left     <= len_ld;
          ptr      <= nm_hit ? (off + cnt) : off;
          phase    <= '0;
          nomove_q <= nm_hit;
          dir_q    <= ctrl.dir;
          fixed_q  <= ctrl.fixed;
          mode_q   <= ctrl.mode;
          step_q   <= step_val(ctrl);
          bank_q   <= bank;
          bidx_q   <= bidx;
        end
      end else begin
        if (done) busy <= 1'b0;
        if (left != '0) begin
          left <= left - LEN_W'(1);
          if (!nomove_q) begin
            iss_v <= 1'b1;
            iss_a <= {bank_q, ptr};
            iss_b <= bidx_q + BIDX_W'(pattern_off(mode_q, phase));
            ptr   <= ptr + step_q;
            phase <= phase + 2'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_pipe.sv
module dma_pipe
  import dma_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_v,
  input  logic              dir,
  input  logic [AW-1:0]     iss_a,
  input  logic [BIDX_W-1:0] iss_b,
  input  logic [DATA_W-1:0] a_rdata,
  input  logic [DATA_W-1:0] b_rdata,
  output logic              data_v,
  output logic              a_req,
  output logic              a_we,
  output logic [AW-1:0]     a_addr,
  output logic [DATA_W-1:0] a_wdata,
  output logic              b_req,
  output logic              b_we,
  output logic [BIDX_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_wdata
);
  logic              s2_v, wr_v;
  logic [AW-1:0]     s2_a, wr_a;
  logic [BIDX_W-1:0] s2_b, wr_b;
  logic [DATA_W-1:0] wr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
      wr_v <= 1'b0;
      s2_a <= '0;
      wr_a <= '0;
      s2_b <= '0;
      wr_b <= '0;
      wr_d <= '0;
    end else begin
      s2_v <= iss_v;
      s2_a <= iss_a;
      s2_b <= iss_b;
      wr_v <= s2_v;
      wr_a <= s2_a;
      wr_b <= s2_b;
      wr_d <= dir ? b_rdata : a_rdata;
    end
  end

  assign data_v  = s2_v;
  assign a_req   = dir ? wr_v : iss_v;
  assign a_we    = dir & wr_v;
  assign a_addr  = dir ? wr_a : iss_a;
  assign a_wdata = wr_d;
  assign b_req   = dir ? iss_v : wr_v;
  assign b_we    = !dir & wr_v;
  assign b_addr  = dir ? iss_b : wr_b;
  assign b_wdata = wr_d;
endmodule

// File: rtl/blk_dma_engine.sv
module blk_dma_engine
  import dma_eng_pkg::*;
#(
  parameter logic [BANK_W-1:0] NM_BANK0 = 8'h7E,
  parameter logic [BANK_W-1:0] NM_BANK1 = 8'h7F,
  parameter logic [BIDX_W-1:0] NM_BIDX  = 8'h80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              start,
  output logic              busy,
  output logic              a_req,
  output logic              a_we,
  output logic [AW-1:0]     a_addr,
  output logic [DATA_W-1:0] a_wdata,
  input  logic [DATA_W-1:0] a_rdata,
  output logic              b_req,
  output logic              b_we,
  output logic [BIDX_W-1:0] b_addr,
  output logic [DATA_W-1:0] b_wdata,
  input  logic [DATA_W-1:0] b_rdata
);
  ctrl_t             cfg_ctrl;
  logic [BIDX_W-1:0] cfg_bidx;
  logic [OFF_W-1:0]  cfg_off;
  logic [BANK_W-1:0] cfg_bank;
  logic [CNT_W-1:0]  cnt_q;
  logic              xfer_done;
  logic [OFF_W-1:0]  wb_off;
  logic              iss_v, data_v, dir_q, fixed_q, nomove_q;
  logic [AW-1:0]     iss_a;
  logic [BIDX_W-1:0] iss_b;
  logic [2:0]        mode_q;

  dma_chan_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .wb_en  (xfer_done),
    .wb_off (wb_off),
    .rdata  (reg_rdata),
    .ctrl   (cfg_ctrl),
    .bidx   (cfg_bidx),
    .off    (cfg_off),
    .bank   (cfg_bank),
    .cnt    (cnt_q)
  );

  dma_seq #(
    .NM_BANK0 (NM_BANK0),
    .NM_BANK1 (NM_BANK1),
    .NM_BIDX  (NM_BIDX)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ctrl      (cfg_ctrl),
    .bidx      (cfg_bidx),
    .off       (cfg_off),
    .bank      (cfg_bank),
    .cnt       (cnt_q),
    .pipe_busy (data_v),
    .busy      (busy),
    .iss_v     (iss_v),
    .iss_a     (iss_a),
    .iss_b     (iss_b),
    .dir_q     (dir_q),
    .fixed_q   (fixed_q),
    .nomove_q  (nomove_q),
    .mode_q    (mode_q),
    .done      (xfer_done),
    .wb_off    (wb_off)
  );

  dma_pipe u_pipe (
    .clk     (clk),
    .rst     (rst),
    .iss_v   (iss_v),
    .dir     (dir_q),
    .iss_a   (iss_a),
    .iss_b   (iss_b),
    .a_rdata (a_rdata),
    .b_rdata (b_rdata),
    .data_v  (data_v),
    .a_req   (a_req),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .b_req   (b_req),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata)
  );
endmodule

// File: rtl/dma_eng_chk.sv
module dma_eng_chk
  import dma_eng_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              a_req,
  input logic [AW-1:0]     a_addr,
  input logic              b_req,
  input logic [BIDX_W-1:0] b_addr,
  input logic [2:0]        mode_q,
  input logic              fixed_q,
  input logic              nomove_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R12
  hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !done |=> busy);

  // R8
  rise_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!a_req && !b_req));

  // R5
  flat_index_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (mode_q == 3'd0 || mode_q == 3'd2 || mode_q == 3'd6) && b_req && $past(b_req))
      |-> $stable(b_addr));

  // R4
  hold_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && fixed_q && !nomove_q && a_req && $past(a_req)) |-> $stable(a_addr));

  // R10
  nomove_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && nomove_q) |-> (!a_req && !b_req));

  // R11
  count_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (cnt_q == '0));
endmodule

bind blk_dma_engine dma_eng_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (xfer_done),
  .a_req    (a_req),
  .a_addr   (a_addr),
  .b_req    (b_req),
  .b_addr   (b_addr),
  .mode_q   (mode_q),
  .fixed_q  (fixed_q),
  .nomove_q (nomove_q),
  .cnt_q    (cnt_q)
);

// File: tb/blk_dma_engine_tb_top.sv
module blk_dma_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd7;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        start = 1'b0;
  logic        busy;
  logic        a_req, a_we, b_req, b_we;
  logic [23:0] a_addr;
  logic [7:0]  a_wdata, b_addr, b_wdata;
  logic [7:0]  a_rdata = 8'h00;
  logic [7:0]  b_rdata = 8'h00;

  int n_chk = 0;
  int n_fail = 0;

  blk_dma_engine dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .start(start), .busy(busy),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
  );

  function automatic logic [7:0] mem_a(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_b(input logic [7:0] b);
    return {b[3:0], b[7:4]} ^ 8'hC3;
  endfunction

  // memory responders: data for a request seen in one cycle is held through the next
  logic        a_rd_prev = 1'b0, b_rd_prev = 1'b0;
  logic [23:0] a_addr_prev = '0;
  logic [7:0]  b_addr_prev = '0;
  always @(negedge clk) begin
    a_rdata     <= a_rd_prev ? mem_a(a_addr_prev) : 8'h00;
    b_rdata     <= b_rd_prev ? mem_b(b_addr_prev) : 8'h00;
    a_rd_prev   <= a_req && !a_we;
    a_addr_prev <= a_addr;
    b_rd_prev   <= b_req && !b_we;
    b_addr_prev <= b_addr;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 3'd7;
  endtask

  task automatic rd_reg(input logic [2:0] s, output logic [7:0] d);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
    reg_sel = 3'd7;
  endtask

  function automatic int pat(input logic [2:0] mode, input int k);
    if (mode == 3'd4) return k % 4;
    if (mode == 3'd1 || mode == 3'd5) return k % 2;
    if (mode == 3'd3 || mode == 3'd7) return (k / 2) % 2;
    return 0;
  endfunction

  function automatic logic [15:0] off_at(input bit dec, input bit fixed,
                                         input logic [15:0] base, input int k);
    if (fixed) return base;
    if (dec) return 16'(int'(base) - k);
    return 16'(int'(base) + k);
  endfunction

  // cycle-by-cycle reference of one transfer; optional stray start pulse mid-run
  task automatic run_xfer(input bit dir, input bit dec, input bit fixed, input logic [2:0] mode,
                          input logic [7:0] bidx, input logic [15:0] off, input logic [7:0] bank,
                          input logic [15:0] cnt, input bit poke, input string tag);
    int n, last, busy_end;
    bit nm;
    logic [7:0] lo, hi;
    logic [15:0] fin;
    wr_reg(3'd0, {dir, 2'b00, dec, fixed, mode});
    wr_reg(3'd1, bidx);
    wr_reg(3'd2, off[7:0]);
    wr_reg(3'd3, off[15:8]);
    wr_reg(3'd4, bank);
    wr_reg(3'd5, cnt[7:0]);
    wr_reg(3'd6, cnt[15:8]);
    n = (cnt == 16'd0) ? 65536 : int'(cnt);
    nm = !dir && (bank == 8'h7E || bank == 8'h7F) && bidx == 8'h80;
    busy_end = nm ? n : n + 2;
    last = busy_end + 1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= last; j++) begin
      logic [63:0] e, a;
      bit rv, wv;
      int rk, wk;
      logic [23:0] ea_addr;
      logic [7:0]  ea_wd, eb_addr, eb_wd;
      bit ea_req, ea_we, eb_req, eb_we;
      rv = !nm && j >= 1 && j <= n;
      wv = !nm && j >= 3 && j <= n + 2;
      rk = j - 1;
      wk = j - 3;
      ea_addr = '0; ea_wd = '0; eb_addr = '0; eb_wd = '0;
      ea_req = 0; ea_we = 0; eb_req = 0; eb_we = 0;
      if (!dir) begin
        ea_req = rv;
        if (rv) ea_addr = {bank, off_at(dec, fixed, off, rk)};
        eb_req = wv; eb_we = wv;
        if (wv) begin
          eb_addr = 8'(int'(bidx) + pat(mode, wk));
          eb_wd = mem_a({bank, off_at(dec, fixed, off, wk)});
        end
      end else begin
        eb_req = rv;
        if (rv) eb_addr = 8'(int'(bidx) + pat(mode, rk));
        ea_req = wv; ea_we = wv;
        if (wv) begin
          ea_addr = {bank, off_at(dec, fixed, off, wk)};
          ea_wd = mem_b(8'(int'(bidx) + pat(mode, wk)));
        end
      end
      e = {11'd0, (j <= busy_end), ea_req, ea_we, ea_addr, ea_wd, eb_req, eb_we, eb_addr, eb_wd};
      a = {11'd0, busy, a_req, a_we, (a_req ? a_addr : 24'd0), (a_we ? a_wdata : 8'd0),
           b_req, b_we, (b_req ? b_addr : 8'd0), (b_we ? b_wdata : 8'd0)};
      check(a === e, tag, $sformatf("cycle %0d bus/busy", j), a, e);
      start = (poke && j == 2) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (nm) fin = 16'(int'(off) + int'(cnt));
    else    fin = off_at(dec, fixed, off, n);
    rd_reg(3'd2, lo);
    rd_reg(3'd3, hi);
    check({hi, lo} === fin, "R11", "final offset", {48'd0, hi, lo}, {48'd0, fin});
    rd_reg(3'd5, lo);
    rd_reg(3'd6, hi);
    check({hi, lo} === 16'h0000, "R11", "count after run", {48'd0, hi, lo}, 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs and reset register contents
    check(!busy && !a_req && !b_req, "R1", "idle outputs", {61'd0, busy, a_req, b_req}, 64'd0);
    rd_reg(3'd0, v); check(v === 8'h0F, "R1", "control reset", {56'd0, v}, 64'h0F);
    rd_reg(3'd1, v); check(v === 8'hFF, "R1", "index reset", {56'd0, v}, 64'hFF);
    rd_reg(3'd2, v); check(v === 8'hFF, "R1", "offset lo reset", {56'd0, v}, 64'hFF);
    rd_reg(3'd3, v); check(v === 8'hFF, "R1", "offset hi reset", {56'd0, v}, 64'hFF);
    rd_reg(3'd4, v); check(v === 8'hFF, "R1", "bank reset", {56'd0, v}, 64'hFF);
    rd_reg(3'd5, v); check(v === 8'hFF, "R1", "count lo reset", {56'd0, v}, 64'hFF);
    rd_reg(3'd6, v); check(v === 8'hFF, "R1", "count hi reset", {56'd0, v}, 64'hFF);
    // R2: register map readback
    wr_reg(3'd0, 8'h95);
    rd_reg(3'd0, v); check(v === 8'h95, "R2", "control readback", {56'd0, v}, 64'h95);
    wr_reg(3'd1, 8'h3C);
    rd_reg(3'd1, v); check(v === 8'h3C, "R2", "index readback", {56'd0, v}, 64'h3C);
    wr_reg(3'd4, 8'hA7);
    rd_reg(3'd4, v); check(v === 8'hA7, "R2", "bank readback", {56'd0, v}, 64'hA7);

    // memory to register, count up, flat pattern
    run_xfer(0, 0, 0, 3'd0, 8'h18, 16'h1000, 8'h12, 16'd5, 0, "R4 R5 R8");
    // count down below zero, pairing pattern with odd count
    run_xfer(0, 1, 0, 3'd1, 8'h22, 16'h0002, 8'h7E, 16'd5, 0, "R4 R6");
    // held offset, doubled pairing pattern
    run_xfer(0, 0, 1, 3'd3, 8'h40, 16'hABCD, 8'h01, 16'd6, 0, "R4 R6");
    // quad pattern, partial last group, index and offset wrap
    run_xfer(0, 0, 0, 3'd4, 8'hFE, 16'hFFFD, 8'h33, 16'd7, 0, "R7 R4");
    run_xfer(0, 0, 0, 3'd2, 8'h05, 16'h0400, 8'h02, 16'd3, 0, "R5");
    run_xfer(0, 1, 0, 3'd6, 8'h06, 16'h0400, 8'h02, 16'd2, 0, "R5");
    run_xfer(0, 0, 0, 3'd5, 8'h31, 16'h0800, 8'h44, 16'd3, 0, "R6");
    // register to memory
    run_xfer(1, 0, 0, 3'd7, 8'h10, 16'h2000, 8'h7F, 16'd4, 0, "R9 R6");
    run_xfer(1, 1, 0, 3'd5, 8'h80, 16'h0100, 8'h7E, 16'd3, 0, "R9 R10");
    run_xfer(1, 0, 0, 3'd4, 8'h20, 16'h3000, 8'h09, 16'd5, 0, "R9 R7");
    // no-op combination: offset moves by count even with count-down set
    run_xfer(0, 1, 0, 3'd1, 8'h80, 16'hFFF8, 8'h7E, 16'd10, 0, "R10");
    run_xfer(0, 0, 1, 3'd0, 8'h80, 16'h0050, 8'h7F, 16'd1, 0, "R10");
    // stray start while running
    run_xfer(0, 0, 0, 3'd2, 8'h11, 16'h0700, 8'h0A, 16'd6, 1, "R12");
    // zero count means the full length
    run_xfer(0, 0, 0, 3'd0, 8'h19, 16'h1234, 8'h05, 16'd0, 0, "R3");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule